// File: doc/BRIEF.md
# Serial Result Shifter with Frame Sync

This block sends a converter result word out on a single data line, most significant bit first. A holding register takes a new word whenever the conversion sequencer signals completion. When a transfer begins, the held word is copied into a separate shift register, so a transfer always sends one whole word.

There are two clock modes. With `ext_mode` low, the block makes its own data clock. Each conversion start sends a burst of exactly WIDTH clock periods, and the burst carries the word held before that start. A conversion start is the moment `cs_n` and `rc` become low together.

With `ext_mode` high, the host supplies the data clock. One rising edge arms the read, and that edge is counted as pulse 0. The next rising edge taken under the read condition (`cs_n` low, `rc` high) raises a frame-sync pulse one host period wide. Data follows on the next edge. A read taken while a conversion is still running returns the earlier word. A read taken after the sequencer has loaded returns the new word.

Top module: `result_serializer`

## Requirements
- R1: While `rst_n` is low, and until the first transfer after reset, `sdata`, `sync` and `int_sclk` are all 0.
- R2: With `ext_mode` low, a conversion start (`cs_n` and `rc` low together, where they were not both low in the previous cycle) produces exactly WIDTH rising edges on `int_sclk`. After the last period, `int_sclk` and `sdata` stay low.
- R3: An internal burst carries the word held before the conversion start. A `load_valid` in the same cycle as the start is kept for the next burst.
- R4: In internal mode, each bit goes out MSB first. It is set one clock before the rise of `int_sclk` and holds through the following fall. The clock is low for HALF cycles and high for HALF cycles in each period.
- R5: In external mode, a host rising edge arms the read only while `cs_n` is high, or while `cs_n` and `rc` are both low. Edges taken with `cs_n` low and `rc` high, from the unarmed state, give no sync and no data.
- R6: Counting the arming edge as pulse 0, `sync` rises on the rising edge of pulse 1, taken under the read condition. It stays high until the rising edge of pulse 2, and it is never high again during that read.
- R7: On the rising edge of pulse k (k = 2 to WIDTH+1), `sdata` shows bit WIDTH+1-k of the word. That is the MSB at pulse 2 and the LSB at pulse WIDTH+1. From pulse WIDTH+2 onward, `sdata` stays low and further edges have no effect until the block is armed again.
- R8: The holding register changes only on `load_valid`. An external read sends the word held when sync rises, so a load made during the shift does not alter the word in flight. The next read returns the loaded word.
- R9: In external mode, `int_sclk` stays low and conversion starts cause no burst. In internal mode, host clock edges never raise `sync`.
- R10: A conversion start that arrives during an internal burst is ignored. The total number of clock periods stays at WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | 1 = host supplies the data clock, 0 = block generates it |
| cs_n | input | 1 | Chip select, active low |
| rc | input | 1 | Read/convert: low selects convert, high selects read |
| load_valid | input | 1 | Sequencer pulse: a new result is on `load_data` |
| load_data | input | WIDTH | New conversion result |
| ext_sclk | input | 1 | Host data clock, synchronous to `clk` |
| sdata | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame-sync pulse in external mode |
| int_sclk | output | 1 | Generated data clock in internal mode |

## Verification
Two things can happen in the same cycle: the sequencer reloads the holding register, and a transfer copies that register into the shifter. The bench raises `load_valid` in the very cycle in which `cs_n` and `rc` first become low together. It requires that burst to carry the old word and the next burst to carry the new one. A second variant loads a word partway through an external read. The bench checks that the captured bits still form the earlier word, and that the following read returns the loaded word.

// File: rtl/result_serializer.sv
module result_serializer #(
  parameter int WIDTH = 16,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             cs_n,
  input  logic             rc,
  input  logic             load_valid,
  input  logic [WIDTH-1:0] load_data,
  input  logic             ext_sclk,
  output logic             sdata,
  output logic             sync,
  output logic             int_sclk
);
  localparam int PER = 2 * HALF;
  localparam int PW  = $clog2(PER);
  localparam int CW  = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST  = CW'(WIDTH - 1);
  localparam logic [PW-1:0] PLAST = PW'(PER - 1);
  localparam logic [PW-1:0] PHALF = PW'(HALF);

  typedef enum logic [1:0] {E_IDLE, E_ARMED, E_SYNC, E_SHIFT} ext_st_t;

  logic [WIDTH-1:0] result_q;
  logic [WIDTH-1:0] shreg;
  logic             ibusy;
  logic [PW-1:0]    ph;
  logic [CW-1:0]    bcnt;
  ext_st_t          estate;
  logic             sclk_d;
  logic             both_low_d;

  wire both_low   = !cs_n && !rc;
  wire conv_start = both_low && !both_low_d;
  wire read_cond  = !cs_n && rc;
  wire arm_cond   = cs_n || both_low;
  wire ext_rise   = ext_sclk && !sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          result_q <= '0;
    else if (load_valid) result_q <= load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      ibusy      <= 1'b0;
      ph         <= '0;
      bcnt       <= '0;
      estate     <= E_IDLE;
      sclk_d     <= 1'b0;
      both_low_d <= 1'b0;
    end else begin
      sclk_d     <= ext_sclk;
      both_low_d <= both_low;
      if (!ext_mode) begin
        estate <= E_IDLE;
        if (!ibusy) begin
          if (conv_start) begin
            ibusy <= 1'b1;
            ph    <= '0;
            bcnt  <= '0;
            shreg <= result_q;
          end
        end else if (ph == PLAST) begin
          ph <= '0;
          if (bcnt == LAST) begin
            ibusy <= 1'b0;
          end else begin
            bcnt  <= bcnt + CW'(1);
            shreg <= {shreg[WIDTH-2:0], 1'b0};
          end
        end else begin
          ph <= ph + PW'(1);
        end
      end else begin
        ibusy <= 1'b0;
        ph    <= '0;
        if (ext_rise) begin
          case (estate)
            E_IDLE:  if (arm_cond) estate <= E_ARMED;
            E_ARMED: if (read_cond) begin
                       estate <= E_SYNC;
                       shreg  <= result_q;
                     end
            E_SYNC:  begin
                       estate <= E_SHIFT;
                       bcnt   <= '0;
                     end
            default: if (bcnt == LAST) begin
                       estate <= E_IDLE;
                     end else begin
                       bcnt  <= bcnt + CW'(1);
                       shreg <= {shreg[WIDTH-2:0], 1'b0};
                     end
          endcase
        end
      end
    end
  end

  assign sync     = (estate == E_SYNC);
  assign int_sclk = ibusy && (ph != '0) && (ph <= PHALF);
  assign sdata    = (ibusy || estate == E_SHIFT) && shreg[WIDTH-1];

endmodule

module result_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_mode,
  input logic ext_sclk,
  input logic sdata,
  input logic sync,
  input logic int_sclk
);
  assert_bit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $past(!ext_mode) && (int_sclk || $past(int_sclk))) |-> $stable(sdata));

  assert_sync_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> ($past(ext_sclk) && !$past(ext_sclk, 2)));

  assert_sync_ends_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode) && $fell(sync)) |-> ($past(ext_sclk) && !$past(ext_sclk, 2)));

  assert_data_quiet_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !sdata);

  assert_no_sync_internal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $past(!ext_mode)) |-> !sync);

  assert_no_clock_external_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode)) |-> !int_sclk);
endmodule

bind result_serializer result_serializer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ext_sclk(ext_sclk),
  .sdata(sdata), .sync(sync), .int_sclk(int_sclk)
);

// File: tb/result_serializer_tb_top.sv
module result_serializer_tb_top;
  logic clk = 0, rst_n = 0, ext_mode = 0, cs_n = 1, rc = 1, load_valid = 0, ext_sclk = 0;
  logic [15:0] load_data = '0;
  logic sdata, sync, int_sclk;
  int checks = 0, errors = 0;
  bit done = 0;

  result_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .cs_n(cs_n), .rc(rc),
    .load_valid(load_valid), .load_data(load_data), .ext_sclk(ext_sclk),
    .sdata(sdata), .sync(sync), .int_sclk(int_sclk)
  );

  always #5 clk = ~clk;

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [15:0] w);
    load_data = w; load_valid = 1; tick; load_valid = 0;
  endtask

  task automatic int_read(input logic [15:0] exp, input logic [15:0] lw, input bit same_load,
                          input bit mid_load, input bit retrig, input string req);
    logic [15:0] got = '0;
    int rises = 0;
    bit prev = 0, unstable = 0, lastbit = 0;
    cs_n = 0; rc = 0;
    if (same_load) begin load_data = lw; load_valid = 1; end
    tick;
    load_valid = 0;
    for (int i = 0; i < 100; i++) begin
      if (int_sclk && !prev) begin got = {got[14:0], sdata}; lastbit = sdata; rises++; end
      if (!int_sclk && prev && sdata != lastbit) unstable = 1;
      prev = int_sclk;
      if (mid_load && i == 20) begin load_data = lw; load_valid = 1; end
      if (retrig && i == 30) cs_n = 1;
      if (retrig && i == 32) cs_n = 0;
      tick;
      load_valid = 0;
    end
    check(rises == 16, "R2 burst length", 16'(rises), 16'd16);
    check(got == exp, req, got, exp);
    check(!unstable, "R4 bit held across rise and fall", 16'(unstable), 16'd0);
    check(!int_sclk && !sdata, "R2 idle after burst", {14'd0, int_sclk, sdata}, 16'd0);
    cs_n = 1; rc = 1; tick;
  endtask

  task automatic ext_pulse(output logic d, output logic s);
    ext_sclk = 1; tick; d = sdata; s = sync; tick;
    ext_sclk = 0; tick; tick;
  endtask

  task automatic ext_read(input logic [15:0] exp, input bit arm_low, input bit load_mid,
                          input logic [15:0] lw, input string req);
    logic d, s;
    logic [15:0] got = '0;
    bit extra_sync = 0;
    if (arm_low) begin cs_n = 0; rc = 0; end else begin cs_n = 1; rc = 1; end
    tick;
    ext_pulse(d, s);
    check(!s, "R6 no sync at arming pulse", {15'd0, s}, 16'd0);
    cs_n = 0; rc = 1; tick;
    ext_pulse(d, s);
    check(s && !d, "R6 sync after pulse 1", {14'd0, s, d}, 16'd2);
    check(sync, "R6 sync held to pulse 2", {15'd0, sync}, 16'd1);
    for (int k = 2; k <= 17; k++) begin
      ext_pulse(d, s);
      got = {got[14:0], d};
      if (s) extra_sync = 1;
      if (load_mid && k == 8) load_word(lw);
    end
    check(got == exp, req, got, exp);
    check(!extra_sync, "R6 single sync", 16'(extra_sync), 16'd0);
    for (int k = 18; k <= 20; k++) begin
      ext_pulse(d, s);
      check(!d && !s, "R7 quiet after LSB", {14'd0, s, d}, 16'd0);
    end
    cs_n = 1; rc = 1; tick;
  endtask

  task automatic ext_unarmed;
    logic d, s;
    bit any = 0;
    cs_n = 0; rc = 1; tick;
    for (int k = 0; k < 4; k++) begin
      ext_pulse(d, s);
      if (d || s) any = 1;
    end
    check(!any, "R5 read edges without arming", 16'(any), 16'd0);
    cs_n = 1; rc = 1; tick;
  endtask

  task automatic mode_isolation;
    logic d, s;
    bit any = 0;
    ext_mode = 1; tick;
    cs_n = 0; rc = 0;
    for (int i = 0; i < 80; i++) begin
      if (int_sclk || sdata) any = 1;
      tick;
    end
    check(!any, "R9 no burst in external mode", 16'(any), 16'd0);
    cs_n = 1; rc = 1; tick;
    ext_mode = 0; tick;
    any = 0;
    ext_pulse(d, s);
    cs_n = 0; rc = 1; tick;
    for (int k = 0; k < 4; k++) begin
      ext_pulse(d, s);
      if (s || d || int_sclk) any = 1;
    end
    check(!any, "R9 host clock ignored in internal mode", 16'(any), 16'd0);
    cs_n = 1; rc = 1; tick;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick;
    check(!sdata && !sync && !int_sclk, "R1 outputs in reset", {13'd0, sdata, sync, int_sclk}, 16'd0);
    rst_n = 1; tick; tick;
    check(!sdata && !sync && !int_sclk, "R1 outputs after reset", {13'd0, sdata, sync, int_sclk}, 16'd0);

    load_word(16'hA5C3);
    int_read(16'hA5C3, 16'h0000, 0, 0, 0, "R3 burst carries held word");
    int_read(16'hA5C3, 16'h1234, 1, 0, 0, "R3 same-cycle load not in burst");
    int_read(16'h1234, 16'hBEEF, 0, 1, 1, "R10 retrigger ignored, word intact");
    int_read(16'hBEEF, 16'h0000, 0, 0, 0, "R8 mid-burst load kept for next");
    load_word(16'h8001);
    int_read(16'h8001, 16'h0000, 0, 0, 0, "R4 MSB first ordering");

    ext_mode = 1; tick;
    ext_read(16'h8001, 0, 0, 16'h0000, "R7 external bit order");
    ext_unarmed();
    ext_read(16'h8001, 1, 1, 16'h0F0F, "R8 read during conversion gives previous");
    ext_read(16'h0F0F, 0, 0, 16'h0000, "R8 next read gives loaded word");
    ext_mode = 0; tick;
    mode_isolation();

    done = 1;
    finish_run();
  end
endmodule